// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital half of a 10-bit successive-approximation converter. It drives a trial code to an external resistor-string tap selector and reads back one comparator bit. Each comparator bit reports whether the selected analog input is at or above the tap voltage. The block settles the code one bit per step, starting at the most significant bit. When the last bit is known, it copies the code into a read-only, left-justified 16-bit result word and raises a one-cycle interrupt.

Software controls the block through two byte-wide registers on a simple memory-mapped bus. The mode register holds an enable bit and a step-duration code. The channel register picks one of seven analog inputs. While the enable bit is set, conversions repeat back to back. Any accepted write to either control register cancels the conversion in flight. In that case the result word keeps its old value and a new conversion starts from the most significant bit. The result can be read as one 16-bit word, so both halves come from the same conversion, or as a byte holding only its upper eight bits.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset the interrupt is low, the trial code is 0, both control registers read back 0x00, and the channel output is 0.
- R2: Bits are settled from bit 9 down to bit 0. A trial bit is kept when `cmp_hi` is 1 (input at or above the trial code) and cleared otherwise. With an ideal comparator, the result equals the analog code.
- R3: Each bit step lasts `2 << t` clock cycles for time code t = 0..4. Codes 5, 6 and 7 select the slowest step, 32 cycles. The interrupt rises 1 + 10·step cycles after the clock edge that takes the enabling write.
- R4: A read at address 0xFF14 returns the 10-bit result in bits 15:6, with bits 5:0 reading 0. A read at 0xFF15 returns the result's upper eight bits in bits 7:0, with bits 15:8 reading 0. The result word changes only in the cycle its interrupt is high.
- R5: `conv_irq` is high for exactly one cycle per completed conversion, in the same cycle the new result becomes readable.
- R6: The channel register at 0xFF81 accepts a byte below 7 and drives it on `ana_sel`. A byte of 7 or more is ignored: it does not change the register and does not disturb a running conversion.
- R7: The mode register at 0xFF80 has the enable bit at bit 7 and the time code at bits 2:0. It reads back the full byte last written.
- R8: While enabled, a new conversion begins on the edge that finishes the previous one, so completions are 10·step cycles apart.
- R9: An accepted control-register write during a conversion cancels it. The result and interrupt are not touched. The trial code reads 0 in the next cycle and 0x200 in the cycle after that.
- R10: When a cancelling write lands on the same edge as the last bit decision, the cancel wins: no interrupt, and the result is not updated.
- R11: Writing the mode register with bit 7 clear stops conversions. The trial code stays 0 and no interrupt occurs.
- R12: Writes to 0xFF14 and 0xFF15 have no effect, and a running conversion finishes on schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| ana_sel | output | 3 | Selected analog channel |
| tap_code | output | 10 | Trial code to the tap selector |
| cmp_hi | input | 1 | Comparator: 1 when input is at or above the tap |
| conv_irq | output | 1 | End-of-conversion pulse |

## Verification
A conversion's final bit decision and a cancelling control-register write can land on the same clock edge. The bench provokes this by counting cycles from one interrupt and placing a channel write exactly 10·step cycles later, after changing the analog value in between. It judges the outcome in three ways. The interrupt must stay low in that cycle. The result must still hold the previous value. The next interrupt must arrive a full 1 + 10·step cycles after the write and carry the new analog value.

// File: rtl/sar_adc_pkg.sv
// Shared constants for the converter sequencer: bus map and default sizes.
// Assumes byte-wide control registers and a 16-bit read path.
package sar_adc_pkg;
    localparam int RES_W     = 10;
    localparam int WORD_W    = 16;
    localparam int CH_W      = 3;
    localparam int NUM_CH    = 7;
    localparam int TSEL_W    = 3;
    localparam int NUM_TSEL  = 5;
    localparam int STEP_BASE = 2;

    localparam logic [15:0] ADDR_RES_LO = 16'hFF14;
    localparam logic [15:0] ADDR_RES_HI = 16'hFF15;
    localparam logic [15:0] ADDR_MODE   = 16'hFF80;
    localparam logic [15:0] ADDR_CHAN   = 16'hFF81;

    localparam int MODE_EN_BIT = 7;
endpackage

// File: rtl/sar_adc_regs.sv
// Control registers: the mode byte (enable, step-time code) and the channel byte.
// A channel write is accepted only when the whole byte is below NUM_CH.
// Every accepted write raises abort_o in the same cycle to cancel a conversion.
// Assumes TSEL_W < 8 and CH_W <= 8.
module sar_adc_regs
    import sar_adc_pkg::*;
#(
    parameter int CH_W   = sar_adc_pkg::CH_W,
    parameter int NUM_CH = sar_adc_pkg::NUM_CH,
    parameter int TSEL_W = sar_adc_pkg::TSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic              en_o,
    output logic [TSEL_W-1:0] tsel_o,
    output logic [CH_W-1:0]   chan_o,
    output logic [7:0]        mode_o,
    output logic              abort_o
);
    logic [7:0]      mode_q;
    logic [CH_W-1:0] chan_q;
    logic            hit_mode;
    logic            hit_chan;

    // Decode accepted writes; an out-of-range channel byte is dropped.
    always_comb begin
        hit_mode = bus_wr && (bus_addr == ADDR_MODE);
        hit_chan = bus_wr && (bus_addr == ADDR_CHAN) && (int'(bus_wdata) < NUM_CH);
        abort_o  = hit_mode || hit_chan;
    end

    // Hold the two control bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            chan_q <= '0;
        end else begin
            if (hit_mode) mode_q <= bus_wdata;
            if (hit_chan) chan_q <= bus_wdata[CH_W-1:0];
        end
    end

    assign en_o   = mode_q[MODE_EN_BIT];
    assign tsel_o = mode_q[TSEL_W-1:0];
    assign chan_o = chan_q;
    assign mode_o = mode_q;

    // R6: the stored channel never leaves the valid range.
    assert_chan_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(chan_q) < NUM_CH);
endmodule

// File: rtl/sar_adc_seq.sv
// Bit-trial sequencer: times each step from the time code, settles one bit per step
// MSB first, and flags completion with the finished code.
// Restarts at once after completion; abort_i cancels and idles for one cycle.
// Assumes en_i is only cleared together with abort_i (a mode write).
module sar_adc_seq #(
    parameter int RES_W     = sar_adc_pkg::RES_W,
    parameter int TSEL_W    = sar_adc_pkg::TSEL_W,
    parameter int NUM_TSEL  = sar_adc_pkg::NUM_TSEL,
    parameter int STEP_BASE = sar_adc_pkg::STEP_BASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [TSEL_W-1:0] tsel_i,
    input  logic              abort_i,
    input  logic              cmp_i,
    output logic [RES_W-1:0]  tap_o,
    output logic              done_o,
    output logic [RES_W-1:0]  res_o
);
    localparam int STEP_MAX = STEP_BASE << (NUM_TSEL - 1);
    localparam int CNT_W    = $clog2(STEP_MAX);
    localparam int IDX_W    = $clog2(RES_W);
    localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(RES_W - 1);
    localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

    // Step length in cycles; unsupported codes take the slowest step.
    function automatic logic [CNT_W:0] step_len(input logic [TSEL_W-1:0] code);
        if (int'(code) < NUM_TSEL) step_len = (CNT_W+1)'(STEP_BASE << code);
        else                       step_len = (CNT_W+1)'(STEP_MAX);
    endfunction

    logic             busy_q;
    logic [RES_W-1:0] sar_q;
    logic [RES_W-1:0] sar_next;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W:0]   cnt_q;
    logic             step_end;

    // Decide the current bit and raise the next trial bit.
    always_comb begin
        step_end = (cnt_q == step_len(tsel_i) - 1'b1);
        sar_next = sar_q;
        sar_next[idx_q] = cmp_i;
        if (idx_q != '0) sar_next[idx_q - 1'b1] = 1'b1;
    end

    // Sequence steps, bits and back-to-back restarts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sar_q  <= '0;
            idx_q  <= '0;
            cnt_q  <= '0;
        end else if (abort_i) begin
            busy_q <= 1'b0;
            sar_q  <= '0;
            idx_q  <= '0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (en_i) begin
                busy_q <= 1'b1;
                sar_q  <= MSB_ONLY;
                idx_q  <= IDX_TOP;
                cnt_q  <= '0;
            end
        end else if (!step_end) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
            if (idx_q != '0) begin
                sar_q <= sar_next;
                idx_q <= idx_q - 1'b1;
            end else begin
                sar_q <= MSB_ONLY;
                idx_q <= IDX_TOP;
            end
        end
    end

    assign tap_o  = sar_q;
    assign done_o = busy_q && step_end && (idx_q == '0) && !abort_i;
    assign res_o  = {sar_q[RES_W-1:1], cmp_i};

    // R2: while converting, the bit under trial is always raised.
    assert_trial_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> sar_q[idx_q]);
    // R3: the trial code holds for the whole step.
    assert_step_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !step_end && !abort_i) |=> (busy_q && $stable(sar_q)));
    // R9: a cancel leaves the sequencer idle with a zero code.
    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!busy_q && sar_q == '0));
endmodule

// File: rtl/sar_adc_result.sv
// Result word and end-of-conversion pulse: captures the finished code on done_i.
// The result is not reset and holds an arbitrary value until the first conversion.
module sar_adc_result #(
    parameter int RES_W = sar_adc_pkg::RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  logic [RES_W-1:0] res_i,
    output logic [RES_W-1:0] res_o,
    output logic             irq_o
);
    logic [RES_W-1:0] res_q;
    logic             irq_q;

    // Capture the code at completion.
    always_ff @(posedge clk) begin
        if (done_i) res_q <= res_i;
    end

    // One-cycle interrupt aligned with the new result.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= done_i;
    end

    assign res_o = res_q;
    assign irq_o = irq_q;

    // R5: the interrupt never lasts two cycles.
    assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    // R4: the result word only moves together with the interrupt.
    assert_res_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_q) |-> irq_q);
endmodule

// File: rtl/sar_adc_ctrl.sv
// Top of the converter sequencer: control registers, bit-trial sequencer,
// result word and the combinational read path.
// Assumes WORD_W >= RES_W >= 8 and an external comparator settled within a step.
module sar_adc_ctrl
    import sar_adc_pkg::*;
#(
    parameter int RES_W     = sar_adc_pkg::RES_W,
    parameter int WORD_W    = sar_adc_pkg::WORD_W,
    parameter int CH_W      = sar_adc_pkg::CH_W,
    parameter int NUM_CH    = sar_adc_pkg::NUM_CH,
    parameter int TSEL_W    = sar_adc_pkg::TSEL_W,
    parameter int NUM_TSEL  = sar_adc_pkg::NUM_TSEL,
    parameter int STEP_BASE = sar_adc_pkg::STEP_BASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [CH_W-1:0]   ana_sel,
    output logic [RES_W-1:0]  tap_code,
    input  logic              cmp_hi,
    output logic              conv_irq
);
    localparam int PAD_W = WORD_W - RES_W;

    logic              en;
    logic [TSEL_W-1:0] tsel;
    logic [7:0]        mode_byte;
    logic              abort;
    logic              done;
    logic [RES_W-1:0]  seq_res;
    logic [RES_W-1:0]  res_word;

    sar_adc_regs #(.CH_W(CH_W), .NUM_CH(NUM_CH), .TSEL_W(TSEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .en_o(en), .tsel_o(tsel), .chan_o(ana_sel),
        .mode_o(mode_byte), .abort_o(abort)
    );

    sar_adc_seq #(.RES_W(RES_W), .TSEL_W(TSEL_W), .NUM_TSEL(NUM_TSEL),
                  .STEP_BASE(STEP_BASE)) u_seq (
        .clk(clk), .rst_n(rst_n), .en_i(en), .tsel_i(tsel), .abort_i(abort),
        .cmp_i(cmp_hi), .tap_o(tap_code), .done_o(done), .res_o(seq_res)
    );

    sar_adc_result #(.RES_W(RES_W)) u_result (
        .clk(clk), .rst_n(rst_n), .done_i(done), .res_i(seq_res),
        .res_o(res_word), .irq_o(conv_irq)
    );

    // Read mux: full left-justified word, upper byte, or control bytes.
    always_comb begin
        unique case (bus_addr)
            ADDR_RES_LO: bus_rdata = {res_word, {PAD_W{1'b0}}};
            ADDR_RES_HI: bus_rdata = {{(WORD_W-8){1'b0}}, res_word[RES_W-1 -: 8]};
            ADDR_MODE:   bus_rdata = {{(WORD_W-8){1'b0}}, mode_byte};
            ADDR_CHAN:   bus_rdata = {{(WORD_W-CH_W){1'b0}}, ana_sel};
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/tb_sar_adc_ctrl.sv
module tb_sar_adc_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [15:0] bus_rdata;
    logic [2:0]  ana_sel;
    logic [9:0]  tap_code;
    logic        cmp_hi;
    logic        conv_irq;
    logic [9:0]  ana [0:7];

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign cmp_hi = (ana[ana_sel] >= tap_code);

    sar_adc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ana_sel(ana_sel),
        .tap_code(tap_code), .cmp_hi(cmp_hi), .conv_irq(conv_irq)
    );

    function automatic int step_of(input int code);
        return (code < 5) ? (2 << code) : 32;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [15:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 16'h0000;
    endtask

    task automatic rd(input logic [15:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
        bus_addr = 16'h0000;
    endtask

    task automatic wait_irq(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!conv_irq && k < 5000);
    endtask

    task automatic check_res(input int exp, input string req);
        int v;
        rd(16'hFF14, v);
        check(v == (exp << 6), req, v, exp << 6);
        rd(16'hFF15, v);
        check(v == (exp >> 2), req, v, exp >> 2);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        int k, v, a_val, b_val, c_val;
        bit bad;
        for (int i = 0; i < 8; i++) ana[i] = 10'h000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(conv_irq == 1'b0, "R1 irq", conv_irq, 0);
        check(tap_code == 10'h0, "R1 tap", tap_code, 0);
        check(ana_sel == 3'd0, "R1 chan out", ana_sel, 0);
        rd(16'hFF80, v); check(v == 0, "R1 mode", v, 0);
        rd(16'hFF81, v); check(v == 0, "R1 chan reg", v, 0);

        // R7/R3/R2/R4/R5: first conversion, fastest step
        ana[0] = 10'h2AB;
        bwrite(16'hFF80, 8'h80);
        wait_irq(k);
        check(k == 21, "R3 first latency", k, 21);
        check_res(10'h2AB, "R2 R4 first result");
        rd(16'hFF80, v); check(v == 8'h80, "R7 mode readback", v, 8'h80);
        ana[0] = 10'd0;
        @(negedge clk);
        check(conv_irq == 1'b0, "R5 pulse width", conv_irq, 0);

        // R2/R8: exhaustive code sweep, back-to-back
        for (int c = 0; c < 1024; c++) begin
            wait_irq(k);
            if (c > 0) check(k == 20, "R8 period", k, 20);
            rd(16'hFF14, v);
            check(v == (c << 6), "R2 sweep", v, c << 6);
            ana[0] = 10'((c + 1) & 10'h3FF);
        end

        // R3: every time code, including unsupported ones
        ana[0] = 10'h1C3;
        for (int t = 0; t < 8; t++) begin
            bwrite(16'hFF80, 8'(8'h80 | t));
            wait_irq(k);
            check(k == 1 + 10 * step_of(t), "R3 latency", k, 1 + 10 * step_of(t));
            wait_irq(k);
            check(k == 10 * step_of(t), "R3 R8 period", k, 10 * step_of(t));
            rd(16'hFF80, v); check(v == (8'h80 | t), "R7 code readback", v, 8'h80 | t);
        end
        bwrite(16'hFF80, 8'h81);

        // R6: each valid channel
        for (int c = 0; c < 7; c++) ana[c] = 10'(100 * c + 37);
        for (int c = 0; c < 7; c++) begin
            bwrite(16'hFF81, 8'(c));
            check(ana_sel == 3'(c), "R6 chan out", ana_sel, c);
            wait_irq(k);
            check(k == 41, "R6 R9 restart", k, 41);
            check_res(100 * c + 37, "R6 chan result");
            rd(16'hFF81, v); check(v == c, "R6 chan readback", v, c);
        end

        // R6: out-of-range channel byte ignored
        wait_irq(k);
        bwrite(16'hFF81, 8'h07);
        wait_irq(k);
        check(k == 39, "R6 code 7 no abort", k, 39);
        check(ana_sel == 3'd6, "R6 code 7 kept", ana_sel, 6);
        bwrite(16'hFF81, 8'h0E);
        rd(16'hFF81, v); check(v == 6, "R6 wide byte ignored", v, 6);

        // R12: writes to result addresses ignored
        wait_irq(k);
        bwrite(16'hFF14, 8'hFF);
        bwrite(16'hFF15, 8'h00);
        wait_irq(k);
        check(k == 38, "R12 no abort", k, 38);
        check_res(637, "R12 result intact");

        // R9: cancel mid conversion
        a_val = 637;
        b_val = 10'h155;
        wait_irq(k);
        ana[6] = 10'(b_val);
        repeat (15) @(negedge clk);
        bwrite(16'hFF81, 8'h06);
        check(tap_code == 10'h000, "R9 idle after cancel", tap_code, 0);
        rd(16'hFF14, v); check(v == (a_val << 6), "R9 result kept", v, a_val << 6);
        @(negedge clk);
        check(tap_code == 10'h200, "R9 restart MSB", tap_code, 10'h200);
        wait_irq(k);
        check(k == 40, "R9 restart latency", k, 40);
        check_res(b_val, "R9 new result");

        // R10: cancel on the completing edge
        c_val = 10'h3C5;
        wait_irq(k);
        ana[6] = 10'(c_val);
        repeat (39) @(negedge clk);
        bwrite(16'hFF81, 8'h06);
        check(conv_irq == 1'b0, "R10 no irq", conv_irq, 0);
        rd(16'hFF14, v); check(v == (b_val << 6), "R10 result kept", v, b_val << 6);
        wait_irq(k);
        check(k == 41, "R10 restart latency", k, 41);
        check_res(c_val, "R10 new result");

        // R11: disable stops conversions
        repeat (7) @(negedge clk);
        bwrite(16'hFF80, 8'h01);
        bad = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (conv_irq || tap_code != 10'h0) bad = 1'b1;
        end
        check(!bad, "R11 stopped", bad, 0);
        rd(16'hFF80, v); check(v == 8'h01, "R11 mode readback", v, 8'h01);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule